// File: doc/BRIEF.md
# Windowed IPC Resource Scaling Controller

This controller watches the number of instructions a superscalar core retires in each cycle. It sums those counts over fixed sampling windows and, once per window, decides whether the core runs in its lean base configuration or in an extended configuration. The extended configuration powers a second integer multiply/divide unit and widens the memory port set from two ports to four.

Two programmable thresholds set the decision, both given in tenths of an instruction per cycle. The up threshold moves the core into the extended configuration. The down threshold moves it back. No division takes place. The window's commit total is compared against the threshold multiplied by the window length divided by ten. The defaults are 2.5 for the up threshold and 4.0 for the down threshold over 10,000 cycles, so the totals compared are 25,000 and 40,000. Each change of configuration is announced by a single-cycle pulse.

Top module: `ipc_scaler`

## Requirements
- R1: After reset the block is in the base state (`ext_mode`=0). Both enables are low, `cfg_change` is low, and a new window starts with an empty commit total.
- R2: A decision is taken only on the last cycle of each window of `WIN` cycles. The state and the enables change only on the clock edge that closes a window.
- R3: The window total includes every cycle of the window, including the commits of the final cycle, and it restarts from zero for the next window.
- R4: In the base state the block enters the extended state when the window total is strictly greater than `thr_up`×`WIN`/10. When the total equals that limit, the block stays in the base state.
- R5: In the extended state the block returns to base when the window total is strictly less than `thr_dn`×`WIN`/10. When the total equals that limit, the block stays extended.
- R6: `mul2_en` and `mem_wide_en` are registered and are high exactly while the state is extended.
- R7: `cfg_change` is high for exactly the one cycle after each state change and is low at all other times.
- R8: A per-cycle commit value above `MAX_COMMIT` (4) is counted as `MAX_COMMIT`.
- R9: The thresholds may change at any time. The values present on the last cycle of a window are the ones used for that window's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_cnt | input | 3 | Instructions committed this cycle |
| thr_up | input | 8 | Up threshold in tenths of IPC |
| thr_dn | input | 8 | Down threshold in tenths of IPC |
| ext_mode | output | 1 | 1 = extended configuration |
| mul2_en | output | 1 | Enable for the second multiply/divide unit |
| mem_wide_en | output | 1 | Enable for memory ports 3 and 4 |
| cfg_change | output | 1 | One-cycle pulse on each state change |

## Verification
The bench runs a 20-cycle window and sweeps every reachable window total from 0 to 80, which covers both sides of each threshold including the equality points. Each total is applied twice: once front-loaded into the first cycles and once back-loaded into the last cycles. The back-loaded case tells a design that drops the final cycle's commits apart from a correct one. Further windows use out-of-range commit values to test the clamp. Other runs move the thresholds in the middle of a window, apply zero thresholds, and apply a reset in the middle of a window, which separates stale-threshold and stale-counter behaviour from the intended behaviour.

// File: rtl/ipc_scaler.sv
module ipc_scaler #(
  parameter int WIN        = 10000,
  parameter int MAX_COMMIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] commit_cnt,
  input  logic [7:0] thr_up,
  input  logic [7:0] thr_dn,
  output logic       ext_mode,
  output logic       mul2_en,
  output logic       mem_wide_en,
  output logic       cfg_change
);
  localparam int CYC_W = $clog2(WIN);
  localparam int ACC_W = $clog2(MAX_COMMIT * WIN + 1);
  localparam int SCALE = WIN / 10;

  logic [CYC_W-1:0] cyc;
  logic [ACC_W-1:0] acc;
  logic [2:0]       commit_c;
  logic [31:0]      total, up_lim, dn_lim;
  logic             last, go_ext, go_base;

  assign commit_c = (int'(commit_cnt) > MAX_COMMIT) ? 3'(MAX_COMMIT) : commit_cnt;
  assign last     = (int'(cyc) == WIN - 1);
  assign total    = 32'(acc) + 32'(commit_c);
  assign up_lim   = 32'(thr_up) * 32'(SCALE);
  assign dn_lim   = 32'(thr_dn) * 32'(SCALE);
  assign go_ext   = last && !ext_mode && (total > up_lim);
  assign go_base  = last &&  ext_mode && (total < dn_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc         <= '0;
      acc         <= '0;
      ext_mode    <= 1'b0;
      mul2_en     <= 1'b0;
      mem_wide_en <= 1'b0;
      cfg_change  <= 1'b0;
    end else begin
      cfg_change <= go_ext || go_base;
      if (last) begin
        cyc <= '0;
        acc <= '0;
      end else begin
        cyc <= cyc + 1'b1;
        acc <= ACC_W'(total);
      end
      if (go_ext) begin
        ext_mode    <= 1'b1;
        mul2_en     <= 1'b1;
        mem_wide_en <= 1'b1;
      end else if (go_base) begin
        ext_mode    <= 1'b0;
        mul2_en     <= 1'b0;
        mem_wide_en <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipc_scaler_chk.sv
module ipc_scaler_chk #(
  parameter int WIN   = 10000,
  parameter int CYC_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CYC_W-1:0] cyc,
  input logic             ext_mode,
  input logic             mul2_en,
  input logic             mem_wide_en,
  input logic             cfg_change
);
  assert_window_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode != $past(ext_mode)) |-> (int'($past(cyc)) == WIN - 1));

  assert_enables_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mul2_en == ext_mode) && (mem_wide_en == ext_mode));

  assert_pulse_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode != $past(ext_mode)) |-> cfg_change);

  assert_pulse_only_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |-> (ext_mode != $past(ext_mode)));

  assert_cycle_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cyc) < WIN);
endmodule

bind ipc_scaler ipc_scaler_chk #(.WIN(WIN), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc(cyc), .ext_mode(ext_mode),
  .mul2_en(mul2_en), .mem_wide_en(mem_wide_en), .cfg_change(cfg_change)
);

// File: tb/ipc_scaler_tb.sv
module ipc_scaler_tb;
  localparam int WIN = 20;
  localparam int MAXC = 4;

  logic clk = 0, rst_n = 0;
  logic [2:0] commit_cnt = 0;
  logic [7:0] thr_up = 25, thr_dn = 40;
  logic ext_mode, mul2_en, mem_wide_en, cfg_change;
  int checks = 0, errors = 0;
  bit exp_ext = 0;

  always #2.5 clk = ~clk;

  ipc_scaler #(.WIN(WIN), .MAX_COMMIT(MAXC)) u_dut (
    .clk(clk), .rst_n(rst_n), .commit_cnt(commit_cnt), .thr_up(thr_up), .thr_dn(thr_dn),
    .ext_mode(ext_mode), .mul2_en(mul2_en), .mem_wide_en(mem_wide_en), .cfg_change(cfg_change));

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int clampv(int v);
    return v < 0 ? 0 : (v > MAXC ? MAXC : v);
  endfunction

  // mode 0 front-loaded, 1 back-loaded, 2 out-of-range values (7 counted as 4)
  task automatic run_window(int total, int mode, string req);
    bit prev = exp_ext;
    for (int i = 0; i < WIN; i++) begin
      if (mode == 0) commit_cnt = 3'(clampv(total - MAXC * i));
      else if (mode == 1) commit_cnt = 3'(clampv(total - MAXC * (WIN - 1 - i)));
      else commit_cnt = (clampv(total - MAXC * i) == MAXC) ? 3'd7 : 3'(clampv(total - MAXC * i));
      @(negedge clk);
      if (i < WIN - 1) begin
        chk({req, " R2 mid-window state"}, ext_mode, prev);
        chk({req, " R7 no pulse mid-window"}, cfg_change, 0);
      end
    end
    if (!exp_ext && total > thr_up * (WIN / 10)) exp_ext = 1;
    else if (exp_ext && total < thr_dn * (WIN / 10)) exp_ext = 0;
    chk({req, " state"}, ext_mode, exp_ext);
    chk({req, " R6 enables"}, {mul2_en, mem_wide_en}, {exp_ext, exp_ext});
    chk({req, " R7 pulse"}, cfg_change, exp_ext != prev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ext", ext_mode, 0);
    chk("R1 enables", {mul2_en, mem_wide_en}, 0);
    chk("R1 pulse", cfg_change, 0);
    rst_n = 1;
    // R4 R5 R3: full sweep of totals, front- and back-loaded
    for (int m = 0; m < 2; m++)
      for (int t = 0; t <= WIN * MAXC; t++)
        run_window(t, m, m ? "R3 R4 R5 back" : "R4 R5 front");
    // R4 equality: base stays at 50
    if (exp_ext) run_window(0, 0, "R5 to base");
    run_window(50, 0, "R4 equal stays base");
    run_window(51, 1, "R4 above enters ext");
    run_window(80, 0, "R5 equal stays ext");
    // R8 clamp: 7 counts as 4
    run_window(80, 2, "R8 clamp holds ext");
    run_window(0, 0, "R5 drop");
    run_window(80, 2, "R8 clamp enters ext");
    run_window(80, 0, "R5 stay");
    // R9: thresholds changed mid-window apply at that boundary
    fork
      begin repeat (5) @(negedge clk); thr_dn = 30; end
      run_window(61, 0, "R9 new down limit");
    join
    fork
      begin repeat (5) @(negedge clk); thr_up = 0; end
      run_window(1, 1, "R9 new up limit");
    join
    thr_dn = 0;
    run_window(0, 0, "R5 zero limit never leaves");
    // reset mid-window
    commit_cnt = 4;
    repeat (7) @(negedge clk);
    rst_n = 0; @(negedge clk);
    chk("R1 mid-run reset ext", ext_mode, 0);
    chk("R1 mid-run reset enables", {mul2_en, mem_wide_en}, 0);
    rst_n = 1; exp_ext = 0; thr_up = 25; thr_dn = 40;
    run_window(50, 1, "R1 R3 fresh window count");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule